// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use, and lets them be reloaded through a one-bit serial data input. Bits are taken on rising edges of a dedicated serial clock while an active-low load strobe and an active-low serial enable are both asserted. A single continuous stream fills both offsets. It starts with the least significant bit of the almost-empty offset and ends with the most significant bit of the almost-full offset. The stream may be paused at any bit and resumed later without losing its place. The FIFO data path can keep running during the pauses.

The bits collect in a shadow register. Both live offsets change together, on the edge that takes the final bit. Each offset has a valid output. Both valid outputs fall as soon as a new stream begins. The almost-full valid is timed by the write clock and the almost-empty valid by the read clock. Each one rises a fixed number of its own clock edges after the final bit. The programming method (serial or parallel) and the width mode are sampled only while master reset is asserted. In the mode where both FIFO buses are 9 bits wide, each offset is one bit wider than in the other modes.

Top module: `serial_ofs_loader`

## Requirements
- R1: In serial mode, one bit of `sdata_i` is taken on each rising `sclk_i` edge at which `ld_ni` and `sen_ni` are both low.
- R2: Stream bit k goes to bit k of the almost-empty offset for k < W, and to bit k-W of the almost-full offset for W <= k < 2W. The first bit of the stream is the least significant bit of the almost-empty offset, and the last bit is the most significant bit of the almost-full offset.
- R3: W is OFS_W+1 when `narrow_mode_i` was high during reset, and OFS_W otherwise. In the OFS_W case, the top bit of each offset output reads 0 after a completed load.
- R4: While `ld_ni` or `sen_ni` is high, no bit is taken. The data on `sdata_i` is ignored, and the next bit taken after both return low is the next bit in order.
- R5: Neither offset output changes before the final bit of a set is taken. Both outputs take their new values on the `sclk_i` edge of the final bit. The following bit then starts a new set at stream bit 0.
- R6: Both valid outputs are low from the `sclk_i` edge that takes stream bit 0 until the final bit of the set has been taken.
- R7: `af_vld_o` rises on the third rising `wclk_i` edge after the final bit. `ae_vld_o` rises on the third rising `rclk_i` edge after the final bit.
- R8: Master reset (`rst_ni` low) loads DEF_EMPTY and DEF_FULL into the offsets, raises both valid outputs and restarts the stream at bit 0. `serial_mode_i` and `narrow_mode_i` are sampled only while reset is low.
- R9: If `serial_mode_i` was low during reset (parallel programming selected), the serial inputs have no effect. The offsets and the valid outputs keep their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial load clock |
| wclk_i | input | 1 | FIFO write clock (times af_vld_o) |
| rclk_i | input | 1 | FIFO read clock (times ae_vld_o) |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| serial_mode_i | input | 1 | 1 selects serial programming; sampled during reset |
| narrow_mode_i | input | 1 | 1 when both FIFO buses are 9 bits wide; sampled during reset |
| ld_ni | input | 1 | Active-low load strobe |
| sen_ni | input | 1 | Active-low serial enable |
| sdata_i | input | 1 | Serial offset data |
| ae_ofs_o | output | OFS_W+1 | Live almost-empty offset |
| af_ofs_o | output | OFS_W+1 | Live almost-full offset |
| ae_vld_o | output | 1 | Almost-empty offset valid (read clock timed) |
| af_vld_o | output | 1 | Almost-full offset valid (write clock timed) |

## Verification
The assertions assume that the mode inputs are held steady through each reset pulse. They also assume that the write and read clocks keep running while a load completes, so that the valid delay can elapse. The stimulus changes the mode inputs only at a falling clock edge, before reset is released. After release it flips `narrow_mode_i`, to show that the mode was captured. All three clocks come from one source, and every input is changed at the falling edge. The pause cycles in the stimulus raise `ld_ni`, `sen_ni` or both, and drive the opposite of the next bit on `sdata_i`, so that a wrongly taken bit would corrupt the loaded offsets.

// File: rtl/ofs_load_pkg.sv
package ofs_load_pkg;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  // counter width able to hold the longest stream length
  function automatic int unsigned cnt_width(int unsigned ofs_w);
    return $clog2(2 * (ofs_w + 1) + 1);
  endfunction

endpackage

// File: rtl/ofs_bit_seq.sv
module ofs_bit_seq
  import ofs_load_pkg::*;
#(
  parameter int unsigned OFS_W = 11,
  parameter int unsigned CNT_W = cnt_width(OFS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             serial_mode_i,
  input  logic             narrow_mode_i,
  input  logic             ld_ni,
  input  logic             sen_ni,
  output logic             take_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] seg_w_o,
  output logic             cfg_ok_o
);

  prog_mode_e       mode_q;
  logic             narrow_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total;
  logic             cfg_ok_q;

  // mode pins are captured only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= prog_mode_e'(serial_mode_i);
      narrow_q <= narrow_mode_i;
    end
  end

  assign seg_w_o = narrow_q ? CNT_W'(OFS_W + 1) : CNT_W'(OFS_W);
  assign total   = seg_w_o << 1;
  assign take_o  = (mode_q == PROG_SERIAL) && !ld_ni && !sen_ni;
  assign last_o  = take_o && (cnt_q == total - CNT_W'(1));
  assign idx_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      cfg_ok_q <= 1'b1;
    end else if (take_o) begin
      if (last_o) begin
        cnt_q    <= '0;
        cfg_ok_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == '0) cfg_ok_q <= 1'b0;
      end
    end
  end

  assign cfg_ok_o = cfg_ok_q;

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < total);

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> $stable(cnt_q));

  // R6
  ok_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cnt_q == '0) |=> !cfg_ok_o);

  // R9
  parallel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PROG_PARALLEL) |-> (cnt_q == '0 && cfg_ok_o));

endmodule

// File: rtl/ofs_shadow.sv
module ofs_shadow #(
  parameter int unsigned OFS_W     = 11,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned DEF_EMPTY = 7,
  parameter int unsigned DEF_FULL  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [CNT_W-1:0] seg_w_i,
  input  logic             sdata_i,
  output logic [OFS_W:0]   ae_ofs_o,
  output logic [OFS_W:0]   af_ofs_o
);

  localparam int unsigned OW = OFS_W + 1;
  localparam int unsigned SW = 2 * OW;
  localparam int unsigned PW = $clog2(SW);

  logic [SW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] pos;
  logic [OW-1:0]    ae_q, af_q;

  // full-offset bits land in the upper half regardless of width mode
  assign pos = (idx_i < seg_w_i) ? idx_i : (idx_i - seg_w_i + CNT_W'(OW));

  always_comb begin
    sh_d = sh_q;
    if (take_i) sh_d[PW'(pos)] = sdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      ae_q <= OW'(DEF_EMPTY);
      af_q <= OW'(DEF_FULL);
    end else begin
      sh_q <= sh_d;
      if (last_i) begin
        ae_q <= sh_d[OW-1:0];
        af_q <= sh_d[SW-1:OW];
      end
    end
  end

  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;

  // R5
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

  // R2
  last_bit_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (af_ofs_o[PW'(seg_w_i) - PW'(1)] == $past(sdata_i)));

endmodule

// File: rtl/ofs_valid_sync.sv
module ofs_valid_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic vld_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= ok_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], ok_i};
      end
    end
  endgenerate

  // fall is immediate, rise waits for the chain
  assign vld_o = sync_q[STAGES-1] & ok_i;

  // R7
  vld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(ok_i));

endmodule

// File: rtl/serial_ofs_loader.sv
module serial_ofs_loader
  import ofs_load_pkg::*;
#(
  parameter int unsigned OFS_W       = 11,
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned DEF_EMPTY   = 7,
  parameter int unsigned DEF_FULL    = 7
) (
  input  logic         sclk_i,
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         serial_mode_i,
  input  logic         narrow_mode_i,
  input  logic         ld_ni,
  input  logic         sen_ni,
  input  logic         sdata_i,
  output logic [OFS_W:0] ae_ofs_o,
  output logic [OFS_W:0] af_ofs_o,
  output logic         ae_vld_o,
  output logic         af_vld_o
);

  localparam int unsigned CNT_W = cnt_width(OFS_W);

  logic             take, last, cfg_ok;
  logic [CNT_W-1:0] idx, seg_w;

  ofs_bit_seq #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_seq (
    .clk_i         (sclk_i),
    .rst_ni        (rst_ni),
    .serial_mode_i (serial_mode_i),
    .narrow_mode_i (narrow_mode_i),
    .ld_ni         (ld_ni),
    .sen_ni        (sen_ni),
    .take_o        (take),
    .last_o        (last),
    .idx_o         (idx),
    .seg_w_o       (seg_w),
    .cfg_ok_o      (cfg_ok)
  );

  ofs_shadow #(
    .OFS_W(OFS_W), .CNT_W(CNT_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)
  ) u_shadow (
    .clk_i    (sclk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .last_i   (last),
    .idx_i    (idx),
    .seg_w_i  (seg_w),
    .sdata_i  (sdata_i),
    .ae_ofs_o (ae_ofs_o),
    .af_ofs_o (af_ofs_o)
  );

  ofs_valid_sync #(.STAGES(SYNC_STAGES)) u_af_vld (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .ok_i   (cfg_ok),
    .vld_o  (af_vld_o)
  );

  ofs_valid_sync #(.STAGES(SYNC_STAGES)) u_ae_vld (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .ok_i   (cfg_ok),
    .vld_o  (ae_vld_o)
  );

  // R1
  take_gate_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (ld_ni || sen_ni) |-> !take);

endmodule

// File: tb/tb_serial_ofs_loader.sv
`timescale 1ns/1ps
module tb_serial_ofs_loader;

  localparam int OFS_W = 3;
  localparam int DEF_E = 5;
  localparam int DEF_F = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic serial_mode_i = 1'b1, narrow_mode_i = 1'b0;
  logic ld_ni = 1'b1, sen_ni = 1'b1, sdata_i = 1'b0;
  logic [OFS_W:0] ae_ofs_o, af_ofs_o;
  logic ae_vld_o, af_vld_o;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  serial_ofs_loader #(
    .OFS_W(OFS_W), .SYNC_STAGES(3), .DEF_EMPTY(DEF_E), .DEF_FULL(DEF_F)
  ) dut (
    .sclk_i(clk), .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni),
    .serial_mode_i(serial_mode_i), .narrow_mode_i(narrow_mode_i),
    .ld_ni(ld_ni), .sen_ni(sen_ni), .sdata_i(sdata_i),
    .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o),
    .ae_vld_o(ae_vld_o), .af_vld_o(af_vld_o)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic ser, logic nar);
    @(negedge clk);
    serial_mode_i = ser; narrow_mode_i = nar; rst_ni = 1'b0;
    ld_ni = 1'b1; sen_ni = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    narrow_mode_i = ~nar;   // must be ignored after reset (R8)
    serial_mode_i = ~ser;
    @(negedge clk);
    chk("R8 ae_ofs default", int'(ae_ofs_o), DEF_E);
    chk("R8 af_ofs default", int'(af_ofs_o), DEF_F);
    chk("R8 ae_vld", int'(ae_vld_o), 1);
    chk("R8 af_vld", int'(af_vld_o), 1);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // stream pattern p of 2W bits with one pause; at a negedge on entry
  task automatic load_set(int p, int w, int old_e, int old_f);
    int total = 2 * w;
    int pause_at = p % (total - 1);
    for (int k = 0; k < total; k++) begin
      ld_ni = 1'b0; sen_ni = 1'b0; sdata_i = p[k];
      step();
      if (k == 0) begin
        chk("R6 ae_vld low after first bit", int'(ae_vld_o), 0);
        chk("R6 af_vld low after first bit", int'(af_vld_o), 0);
        chk("R5 ae_ofs unchanged mid-set", int'(ae_ofs_o), old_e);
      end
      if (k == pause_at) begin
        case (p % 3)
          0:       begin ld_ni = 1'b1; sen_ni = 1'b0; end
          1:       begin ld_ni = 1'b0; sen_ni = 1'b1; end
          default: begin ld_ni = 1'b1; sen_ni = 1'b1; end
        endcase
        sdata_i = ~p[k + 1];
        step();
        chk("R4 af_ofs unchanged in pause", int'(af_ofs_o), old_f);
        chk("R6 af_vld low in pause", int'(af_vld_o), 0);
      end
    end
    ld_ni = 1'b1; sen_ni = 1'b1; sdata_i = 1'b0;
    // R2/R3: arithmetic split of the stream
    chk("R2 ae_ofs loaded", int'(ae_ofs_o), p % (1 << w));
    chk("R2 af_ofs loaded", int'(af_ofs_o), p >> w);
    chk("R6 ae_vld low at last bit", int'(ae_vld_o), 0);
    step();
    step();
    chk("R7 af_vld low after 2 edges", int'(af_vld_o), 0);
    chk("R7 ae_vld low after 2 edges", int'(ae_vld_o), 0);
    step();
    chk("R7 af_vld high after 3 edges", int'(af_vld_o), 1);
    chk("R7 ae_vld high after 3 edges", int'(ae_vld_o), 1);
  endtask

  initial begin
    int e, f, w;
    // narrow (W=OFS_W+1) then wide (W=OFS_W): exhaustive patterns
    for (int nar = 1; nar >= 0; nar--) begin
      w = (nar != 0) ? OFS_W + 1 : OFS_W;
      do_reset(1'b1, logic'(nar));
      e = DEF_E; f = DEF_F;
      for (int p = 0; p < (1 << (2 * w)); p++) begin
        load_set(p, w, e, f);
        e = p % (1 << w);
        f = p >> w;
        if (nar == 0)
          chk("R3 top bits zero in wide mode", int'(ae_ofs_o[OFS_W] | af_ofs_o[OFS_W]), 0);
      end
    end
    // R1/R5: back-to-back sets restart at bit 0
    do_reset(1'b1, 1'b0);
    load_set(6'h2d, OFS_W, DEF_E, DEF_F);
    load_set(6'h13, OFS_W, 6'h2d % 8, 6'h2d >> 3);
    chk("R1 second set empty", int'(ae_ofs_o), 3);
    chk("R1 second set full", int'(af_ofs_o), 2);
    // R9: parallel mode ignores the serial inputs
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      ld_ni = 1'b0; sen_ni = 1'b0; sdata_i = k[0];
      step();
      chk("R9 ae_vld stays high", int'(ae_vld_o), 1);
    end
    ld_ni = 1'b1; sen_ni = 1'b1;
    step();
    chk("R9 ae_ofs unchanged", int'(ae_ofs_o), DEF_E);
    chk("R9 af_ofs unchanged", int'(af_ofs_o), DEF_F);
    chk("R9 af_vld stays high", int'(af_vld_o), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule